// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block keeps the two threshold offsets that a FIFO's flag logic compares against the fill level. One offset sets how close to empty the "almost empty" flag fires. The other sets how close to full the "almost full" flag fires. A strap input is sampled while master reset is held, and it does two things. It picks the default value that both offsets take, and it fixes for the rest of operation how software may load new values: as whole words from a parallel data bus, or bit by bit through a serial input.

After reset, an access-enable input opens the registers. In serial mode, each rising clock edge that sees the access enable and the shift enable both asserted takes one bit into the offsets. The stream starts with the almost-empty offset, least significant bit first, and then fills the almost-full offset. In parallel mode, each access writes or reads one whole offset. A shared pointer moves from the almost-empty offset to the almost-full offset and back. Read-back exists only in parallel mode. The flag comparators and the FIFO storage lie outside this block.

Top module: `ofs_loader`

## Requirements
- R1: A clock edge with `rst` high and `cfg_strap` low sets both offsets to 127 (0x07F) and selects parallel loading (`serial_mode` = 0).
- R2: A clock edge with `rst` high and `cfg_strap` high sets both offsets to 1023 (0x3FF) and selects serial loading (`serial_mode` = 1).
- R3: In serial mode, each edge with `acc_en` and `sh_en` both high stores `sh_bit` into the next bit position. Bit positions 0..OFS_W-1 of the almost-empty offset come first, then positions 0..OFS_W-1 of the almost-full offset.
- R4: In serial mode, an edge with `sh_en` low or `acc_en` low leaves both offsets unchanged.
- R5: After 2*OFS_W serial bits, further bits are ignored until `acc_en` has been low for at least one edge. The next bit then goes to bit 0 of the almost-empty offset. A stream that is cut off part way, by `acc_en` going low before 2*OFS_W bits, resumes at the following bit position.
- R6: In parallel mode, each edge with `acc_en` and `wr_en` high writes `wr_data[OFS_W-1:0]` to the offset the pointer selects, then moves the pointer on. The almost-empty offset comes first, then the almost-full offset, then the almost-empty offset again.
- R7: In parallel mode, an edge with `acc_en` and `rd_en` high and `wr_en` low loads the selected offset, zero-extended, into `rd_data` from the next cycle onward, and moves the same pointer on. If `wr_en` is also high, the write takes that edge.
- R8: The loading method does not change after reset. In serial mode, parallel writes leave the offsets unchanged and parallel reads leave `rd_data` unchanged. In parallel mode, serial shifting leaves the offsets unchanged.
- R9: Reset clears `rd_data` to 0. It also returns both the pointer and the serial bit position to the start of the almost-empty offset.
- R10: With `acc_en` low, `wr_en`, `rd_en` and `sh_en` change neither the offsets nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high master reset |
| cfg_strap | input | 1 | Strap sampled during reset: 0 gives parallel loading with 127 defaults, 1 gives serial loading with 1023 defaults |
| acc_en | input | 1 | Opens the offset registers for access |
| wr_en | input | 1 | Parallel write request |
| rd_en | input | 1 | Parallel read request |
| wr_data | input | DATA_W | Parallel write data; the low OFS_W bits are used |
| sh_en | input | 1 | Serial shift enable |
| sh_bit | input | 1 | Serial data bit |
| empty_ofs | output | OFS_W | Almost-empty threshold offset |
| full_ofs | output | OFS_W | Almost-full threshold offset |
| rd_data | output | DATA_W | Last offset read back, zero-extended |
| serial_mode | output | 1 | 1 when serial loading was selected at reset |

## Verification
A pointer that is out of step shows up quickly. The next parallel write lands in the wrong offset, which is visible on `empty_ofs` or `full_ofs` one cycle after that edge. The next read returns the wrong offset on `rd_data` in the cycle after the read. A serial bit position that is off, or a missed end-of-stream stop, corrupts a bit of an offset in the cycle after the faulty shift. A stuck stop appears as an offset that holds where a bit should have landed. A mode latch that drifts after reset lets accesses of the wrong kind through, and these show at the outputs one cycle later.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    localparam int unsigned DEF_NARROW = 127;
    localparam int unsigned DEF_WIDE   = 1023;

    // Update request handed from the sequencer to the register file
    typedef struct packed {
        logic     par_we;
        ofs_sel_e sel;
        logic     ser_we;
        logic     ser_bit;
    } ofs_cmd_t;

    function automatic logic [31:0] default_offset(input load_mode_e m);
        return (m == LOAD_SERIAL) ? 32'(DEF_WIDE) : 32'(DEF_NARROW);
    endfunction

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/ofs_loader_seq.sv
module ofs_loader_seq
    import ofs_loader_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int IDX_W = $clog2(2 * OFS_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  load_mode_e       mode,
    input  logic             acc_en,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             sh_en,
    input  logic             sh_bit,
    output ofs_cmd_t         cmd,
    output logic [IDX_W-1:0] bit_pos,
    output logic             rd_take,
    output ofs_sel_e         rd_sel
);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(2 * OFS_W - 1);

    ofs_sel_e         ptr_q;
    logic [IDX_W-1:0] pos_q;
    logic             done_q;
    logic             par_write, par_read, ser_step;

    always_comb begin
        par_write = (mode == LOAD_PARALLEL) && acc_en && wr_en;
        par_read  = (mode == LOAD_PARALLEL) && acc_en && rd_en && !wr_en;
        ser_step  = (mode == LOAD_SERIAL) && acc_en && sh_en && !done_q;
    end

    // Shared word pointer for parallel writes and reads
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= SEL_EMPTY;
        end else if (par_write || par_read) begin
            ptr_q <= next_sel(ptr_q);
        end
    end

    // Serial bit position and end-of-stream stop
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            done_q <= 1'b0;
        end else if (ser_step) begin
            if (pos_q == LAST_POS) begin
                pos_q  <= '0;
                done_q <= 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end else if (!acc_en) begin
            done_q <= 1'b0;
        end
    end

    always_comb begin
        cmd.par_we  = par_write;
        cmd.sel     = ptr_q;
        cmd.ser_we  = ser_step;
        cmd.ser_bit = sh_bit;
        bit_pos     = pos_q;
        rd_take     = par_read;
        rd_sel      = ptr_q;
    end

    // R5: bit position never leaves the two-offset stream
    p_pos_range_r5: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    // R5: once stopped, no shift is issued while access stays open
    p_stop_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (done_q && acc_en) |=> !cmd.ser_we);

endmodule

// File: rtl/ofs_loader_regs.sv
module ofs_loader_regs
    import ofs_loader_pkg::*;
#(
    parameter int OFS_W  = 12,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(2 * OFS_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  load_mode_e        rst_mode,
    input  ofs_cmd_t          cmd,
    input  logic [IDX_W-1:0]  bit_pos,
    input  logic [DATA_W-1:0] par_data,
    input  logic              rd_take,
    input  ofs_sel_e          rd_sel,
    output logic [OFS_W-1:0]  empty_q,
    output logic [OFS_W-1:0]  full_q,
    output logic [DATA_W-1:0] rd_q
);
    logic [31:0]      dflt;
    logic             in_full;
    logic [IDX_W-1:0] local_pos;
    logic [OFS_W-1:0] bmask, bval;

    always_comb begin
        dflt      = default_offset(rst_mode);
        in_full   = bit_pos >= IDX_W'(OFS_W);
        local_pos = in_full ? bit_pos - IDX_W'(OFS_W) : bit_pos;
        bmask     = OFS_W'(1) << local_pos;
        bval      = {OFS_W{cmd.ser_bit}} & bmask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= dflt[OFS_W-1:0];
            full_q  <= dflt[OFS_W-1:0];
        end else if (cmd.par_we) begin
            if (cmd.sel == SEL_EMPTY) empty_q <= par_data[OFS_W-1:0];
            else                      full_q  <= par_data[OFS_W-1:0];
        end else if (cmd.ser_we) begin
            if (in_full) full_q  <= (full_q & ~bmask) | bval;
            else         empty_q <= (empty_q & ~bmask) | bval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_take) begin
            rd_q <= DATA_W'((rd_sel == SEL_FULL) ? full_q : empty_q);
        end
    end

    // R7: a read never alters the stored offsets
    p_read_keeps_ofs_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_take && !cmd.par_we && !cmd.ser_we) |=> ($stable(empty_q) && $stable(full_q)));

    // R3: a serial step changes at most one bit across both offsets
    p_one_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.ser_we && !cmd.par_we) |=>
            ($countones({empty_q, full_q} ^ $past({empty_q, full_q})) <= 1));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofs_loader_pkg::*;
#(
    parameter int OFS_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_strap,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sh_en,
    input  logic              sh_bit,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              serial_mode
);
    localparam int IDX_W = $clog2(2 * OFS_W);

    load_mode_e       mode_q;
    load_mode_e       strap_mode;
    ofs_cmd_t         cmd;
    logic [IDX_W-1:0] bit_pos;
    logic             rd_take;
    ofs_sel_e         rd_sel;

    assign strap_mode = cfg_strap ? LOAD_SERIAL : LOAD_PARALLEL;

    // Loading method is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) mode_q <= strap_mode;
    end

    ofs_loader_seq #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_q),
        .acc_en  (acc_en),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .sh_en   (sh_en),
        .sh_bit  (sh_bit),
        .cmd     (cmd),
        .bit_pos (bit_pos),
        .rd_take (rd_take),
        .rd_sel  (rd_sel)
    );

    ofs_loader_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rst_mode (strap_mode),
        .cmd      (cmd),
        .bit_pos  (bit_pos),
        .par_data (wr_data),
        .rd_take  (rd_take),
        .rd_sel   (rd_sel),
        .empty_q  (empty_ofs),
        .full_q   (full_ofs),
        .rd_q     (rd_data)
    );

    assign serial_mode = (mode_q == LOAD_SERIAL);

    // R1: narrow defaults and parallel loading after a low strap
    p_default_narrow_r1: assert property (@(posedge clk)
        (rst && !cfg_strap) |=> (empty_ofs == OFS_W'(DEF_NARROW) &&
                                 full_ofs == OFS_W'(DEF_NARROW) && !serial_mode));

    // R2: wide defaults and serial loading after a high strap
    p_default_wide_r2: assert property (@(posedge clk)
        (rst && cfg_strap) |=> (empty_ofs == OFS_W'(DEF_WIDE) &&
                                full_ofs == OFS_W'(DEF_WIDE) && serial_mode));

    // R8: loading method fixed outside reset
    p_mode_locked_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(serial_mode));

    // R4: serial offsets hold without both enables
    p_serial_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (serial_mode && !(acc_en && sh_en)) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R8: no read-back in serial mode
    p_no_serial_read_r8: assert property (@(posedge clk) disable iff (rst)
        serial_mode |=> $stable(rd_data));

    // R8: parallel offsets move only on a write
    p_par_only_write_r8: assert property (@(posedge clk) disable iff (rst)
        (!serial_mode && !(acc_en && wr_en)) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R10: nothing changes without access enable
    p_no_access_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(rd_data)));

endmodule

// File: tb/ofs_loader_bench.sv
`timescale 1ns/1ps
module ofs_loader_bench;
    localparam int W  = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst, cfg_strap, acc_en, wr_en, rd_en, sh_en, sh_bit;
    logic [DW-1:0] wr_data;
    logic [W-1:0]  empty_ofs, full_ofs;
    logic [DW-1:0] rd_data;
    logic          serial_mode;

    always #2.5 clk = ~clk;

    ofs_loader #(.OFS_W(W), .DATA_W(DW)) u_ofs_loader (
        .clk(clk), .rst(rst), .cfg_strap(cfg_strap), .acc_en(acc_en),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .sh_en(sh_en),
        .sh_bit(sh_bit), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .rd_data(rd_data), .serial_mode(serial_mode)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic [W-1:0]  m_ae, m_af;
    logic [DW-1:0] m_rd;
    logic          m_ser, m_ptr, m_done;
    int            m_pos;
    string         tag;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        tag = "R10";
        if (rst) begin
            m_ser = cfg_strap;
            m_ae = cfg_strap ? W'(1023) : W'(127);
            m_af = m_ae;
            m_ptr = 0; m_pos = 0; m_done = 0; m_rd = '0;
            tag = cfg_strap ? "R2" : "R1";
        end else if (m_ser) begin
            tag = "R4";
            if (acc_en && sh_en && !m_done) begin
                if (m_pos < W) m_ae[m_pos] = sh_bit;
                else           m_af[m_pos - W] = sh_bit;
                if (m_pos == 2 * W - 1) begin m_pos = 0; m_done = 1; end
                else m_pos++;
                tag = "R3";
            end else if (acc_en && (wr_en || rd_en)) begin
                tag = "R8";
            end else if (!acc_en) begin
                m_done = 0;
                tag = "R5";
            end
        end else begin
            if (acc_en && wr_en) begin
                if (m_ptr) m_af = wr_data[W-1:0];
                else       m_ae = wr_data[W-1:0];
                m_ptr = !m_ptr;
                tag = "R6";
            end else if (acc_en && rd_en) begin
                m_rd = DW'(m_ptr ? m_af : m_ae);
                m_ptr = !m_ptr;
                tag = "R7";
            end else if (acc_en && sh_en) begin
                tag = "R8";
            end
        end
    endtask

    // One clock: inputs already set; model updates at the edge; compare mid-low
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "empty_ofs", 32'(empty_ofs), 32'(m_ae));
        chk(tag, "full_ofs", 32'(full_ofs), 32'(m_af));
        chk(tag, "rd_data", 32'(rd_data), 32'(m_rd));
        chk(tag, "serial_mode", 32'(serial_mode), 32'(m_ser));
    endtask

    task automatic idle();
        acc_en = 0; wr_en = 0; rd_en = 0; sh_en = 0; sh_bit = 0; wr_data = '0;
    endtask

    task automatic do_reset(input logic strap);
        idle();
        rst = 1; cfg_strap = strap;
        step(); step();
        rst = 0;
        cfg_strap = !strap;
    endtask

    task automatic pwrite(input logic [DW-1:0] d);
        acc_en = 1; wr_en = 1; rd_en = 0; sh_en = 0; wr_data = d;
        step(); idle();
    endtask

    task automatic pread();
        acc_en = 1; rd_en = 1; wr_en = 0; sh_en = 0;
        step(); idle();
    endtask

    task automatic shift(input logic b);
        acc_en = 1; sh_en = 1; sh_bit = b; wr_en = 0; rd_en = 0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2*W-1:0] pat;
        void'($urandom(32'h1F2E3D4C));
        idle();

        // R1 / R9: parallel defaults
        do_reset(1'b0);
        chk("R1", "empty default", 32'(empty_ofs), 32'd127);
        chk("R1", "full default", 32'(full_ofs), 32'd127);
        chk("R1", "parallel mode", 32'(serial_mode), 32'd0);
        chk("R9", "rd_data reset", 32'(rd_data), 32'd0);

        // R6: alternating writes, pointer wraps
        pwrite(16'h00A5);
        chk("R6", "first write to empty", 32'(empty_ofs), 32'h0A5);
        pwrite(16'hF3C1);
        chk("R6", "second write to full", 32'(full_ofs), 32'h3C1);
        pwrite(16'h0777);
        chk("R6", "third write wraps to empty", 32'(empty_ofs), 32'h777);
        chk("R6", "full untouched", 32'(full_ofs), 32'h3C1);
        // pointer now at full; write it to return to empty
        pwrite(16'h0222);
        // R7: reads in same order
        pread();
        chk("R7", "read empty", 32'(rd_data), 32'h777);
        pread();
        chk("R7", "read full", 32'(rd_data), 32'h222);
        // R10: no access enable
        wr_en = 1; rd_en = 1; sh_en = 1; wr_data = 16'h0BBB; step(); idle();
        chk("R10", "write without access", 32'(empty_ofs), 32'h777);
        // R8: serial shift ignored in parallel mode
        repeat (4) shift(1'b0);
        idle();
        chk("R8", "shift ignored in parallel", 32'(empty_ofs), 32'h777);

        // R2: serial defaults
        do_reset(1'b1);
        chk("R2", "empty default", 32'(empty_ofs), 32'd1023);
        chk("R2", "full default", 32'(full_ofs), 32'd1023);
        chk("R2", "serial mode", 32'(serial_mode), 32'd1);

        // R9: partial stream, then reset restarts position
        repeat (5) shift(1'b0);
        do_reset(1'b1);
        // R3: full stream, LSB first, empty offset then full offset
        pat = 24'h5A3C96;
        for (int i = 0; i < 2 * W; i++) shift(pat[i]);
        chk("R3", "serial empty", 32'(empty_ofs), 32'hC96);
        chk("R3", "serial full", 32'(full_ofs), 32'h5A3);
        // R5: extra bits ignored while access stays open
        repeat (3) shift(1'b1);
        chk("R5", "stopped after stream", 32'(empty_ofs), 32'hC96);
        idle(); step();
        shift(1'b1);
        chk("R5", "restart at empty bit0", 32'(empty_ofs), 32'hC97);
        // R4: shift enable low
        acc_en = 1; sh_en = 0; sh_bit = 0; step();
        chk("R4", "hold without shift enable", 32'(empty_ofs), 32'hC97);
        // R8: parallel access ignored in serial mode
        idle(); pwrite(16'h0001); pread();
        chk("R8", "no parallel write", 32'(empty_ofs), 32'hC97);
        chk("R8", "no serial read-back", 32'(rd_data), 32'd0);

        // Random rounds
        for (int r = 0; r < 6; r++) begin
            do_reset(1'($urandom_range(0, 1)));
            for (int c = 0; c < 400; c++) begin
                acc_en  = ($urandom_range(0, 3) != 0);
                wr_en   = 1'($urandom_range(0, 1));
                rd_en   = 1'($urandom_range(0, 1));
                sh_en   = ($urandom_range(0, 3) != 0);
                sh_bit  = 1'($urandom_range(0, 1));
                wr_data = DW'($urandom);
                step();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule